// File: doc/BRIEF.md
# Lockable System Control Register File

This block is a small register file on a plain 32-bit memory-mapped bus with byte offsets. It holds a fixed board identity word, an LED register that drives output pins, and two general configuration words. It also holds two flag registers, each written through a set address and a separate clear address. A reset-control register can be written only after software has stored a magic key in a lock register. One bit of that register makes the block issue a one-cycle system reset request.

Most other word offsets in the map are reserved or fixed. They read back a constant or zero and do not react to writes. An access that falls outside the defined map reads zero and sets a sticky error indication.

Read data is registered and is valid one cycle after the read strobe. The volatile state is cleared by a synchronous active-low soft reset. The non-volatile flag register is cleared only by a separate active-low power-on reset.

Top module: `sysreg_lockfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, the LED, both config words, the volatile flags, the lock register, the reset-control register, the read data, the error flag and the reset request are all cleared to 0.
- R2: Fixed reads: offset 0x00 returns the parameter `SYS_ID`. 0x44 returns 0x1. 0x50 returns 0x1000. 0x84 returns 0x02000000. 0x88 returns 0xFF000000. Every other defined offset that holds no state returns 0. A write to any fixed or zero offset changes nothing.
- R3: Offsets 0x08 (LED), 0x28 and 0x2C (config A, config B) are plain 32-bit read/write registers. `led_out` always equals the LED register.
- R4: A write to the lock register at 0x20 with data exactly 0x0000A05F stores 0xA05F. Any other data stores its bits 14:0 with bit 15 forced to 0. A read returns the 16-bit value zero-extended.
- R5: A write to the reset-control register at 0x40 stores the full data only while the lock register holds 0xA05F. Otherwise the write leaves the register unchanged. Reads return the stored value.
- R6: An accepted write to 0x40 with data bit 8 set drives `sys_reset_req` high for exactly the one cycle after the write edge. A locked write, or an accepted write with bit 8 clear, gives no pulse.
- R7: The volatile flags read at 0x30. A write to 0x30 ORs the data into the flags. A write to 0x34 clears every flag bit that is 1 in the data. A read of 0x34 returns 0.
- R8: The non-volatile flags read at 0x38. They are set through 0x38 and cleared through 0x3C in the same way as R7. A read of 0x3C returns 0.
- R9: The non-volatile flags keep their value through `rst_n` and are cleared only when `por_n` is low at a clock edge.
- R10: `bus_rdata` updates on the clock edge at which `bus_rd` is high and holds its value in all cycles without a read.
- R11: The defined map is every word offset from 0x00 to 0x74, 0x80 to 0x9C, and 0xC0 to 0xD0. A read or write at any other offset, or with address bits 1:0 nonzero, reads 0, changes no register, and sets `bad_access`. `bad_access` stays set until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low soft reset |
| por_n | input | 1 | Synchronous active-low power-on reset for the non-volatile flags |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| led_out | output | DATA_W | LED register contents |
| sys_reset_req | output | 1 | One-cycle system reset request |
| bad_access | output | 1 | Sticky undefined-access flag |

## Verification
The bench sweeps every word offset after reset and compares each read with a value computed from the map. A decoder that shifted a constant, or that misclassified an offset, would show up as a wrong value or a wrong `bad_access`. Each fixed or reserved offset is written with all ones and read back, which exposes a write decode that leaks into a neighbouring register.

The lock is probed with near-miss keys. These include the key with extra upper bits set, which must store 0x205F and stay locked, and values with bit 15 set, which must have it cleared. A design that compared only 16 bits, or that kept bit 15, would unlock by mistake.

The flag banks are driven with pseudo-random set and clear masks against a bench model. The non-volatile bank is then taken through a soft reset, which a design with shared reset wiring would wipe. Reset pulses are sampled in the cycle after the write and in the cycle after that, which catches a missing, late or stretched pulse.

// File: rtl/sysreg_pkg.sv
// sysreg_pkg
// Shared offsets, constants and the decoded register-select type for the
// lockable system control register file. Assumes byte offsets, word aligned.
package sysreg_pkg;

    // Offsets with behaviour of their own
    localparam logic [31:0] OFS_ID       = 32'h00;
    localparam logic [31:0] OFS_LED      = 32'h08;
    localparam logic [31:0] OFS_LOCK     = 32'h20;
    localparam logic [31:0] OFS_CFG_A    = 32'h28;
    localparam logic [31:0] OFS_CFG_B    = 32'h2C;
    localparam logic [31:0] OFS_FLG_SET  = 32'h30;
    localparam logic [31:0] OFS_FLG_CLR  = 32'h34;
    localparam logic [31:0] OFS_NVF_SET  = 32'h38;
    localparam logic [31:0] OFS_NVF_CLR  = 32'h3C;
    localparam logic [31:0] OFS_RSTCTL   = 32'h40;
    localparam logic [31:0] OFS_K_PCI    = 32'h44;
    localparam logic [31:0] OFS_K_LCD    = 32'h50;
    localparam logic [31:0] OFS_K_TILE0  = 32'h84;
    localparam logic [31:0] OFS_K_TILE1  = 32'h88;

    // Windows of defined offsets that otherwise read zero
    localparam logic [31:0] WIN0_LO = 32'h00;
    localparam logic [31:0] WIN0_HI = 32'h74;
    localparam logic [31:0] WIN1_LO = 32'h80;
    localparam logic [31:0] WIN1_HI = 32'h9C;
    localparam logic [31:0] WIN2_LO = 32'hC0;
    localparam logic [31:0] WIN2_HI = 32'hD0;

    // Fixed read values
    localparam logic [31:0] K_PCI_VAL   = 32'h0000_0001;
    localparam logic [31:0] K_LCD_VAL   = 32'h0000_1000;
    localparam logic [31:0] K_TILE0_VAL = 32'h0200_0000;
    localparam logic [31:0] K_TILE1_VAL = 32'hFF00_0000;

    // Decoded register selection
    typedef enum logic [4:0] {
        SEL_NONE,
        SEL_ID,
        SEL_LED,
        SEL_LOCK,
        SEL_CFG_A,
        SEL_CFG_B,
        SEL_FLG_SET,
        SEL_FLG_CLR,
        SEL_NVF_SET,
        SEL_NVF_CLR,
        SEL_RSTCTL,
        SEL_K_PCI,
        SEL_K_LCD,
        SEL_K_TILE0,
        SEL_K_TILE1,
        SEL_ZERO
    } sel_e;

endpackage

// File: rtl/sysreg_decode.sv
// sysreg_decode
// Combinational address decoder. Maps a byte offset onto a register
// selection. Assumes ADDR_W >= 8. Unaligned or out-of-map offsets give
// SEL_NONE.
module sysreg_decode
    import sysreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);

    logic [31:0] a32;
    logic        in_window;

    assign a32 = 32'(addr);

    // Purpose: flag offsets that lie inside one of the defined windows
    always_comb begin
        in_window = ((a32 >= WIN0_LO) && (a32 <= WIN0_HI)) ||
                    ((a32 >= WIN1_LO) && (a32 <= WIN1_HI)) ||
                    ((a32 >= WIN2_LO) && (a32 <= WIN2_HI));
    end

    // Purpose: pick the register for an aligned offset
    always_comb begin
        sel = SEL_NONE;
        if (a32[1:0] == 2'b00) begin
            case (a32)
                OFS_ID:      sel = SEL_ID;
                OFS_LED:     sel = SEL_LED;
                OFS_LOCK:    sel = SEL_LOCK;
                OFS_CFG_A:   sel = SEL_CFG_A;
                OFS_CFG_B:   sel = SEL_CFG_B;
                OFS_FLG_SET: sel = SEL_FLG_SET;
                OFS_FLG_CLR: sel = SEL_FLG_CLR;
                OFS_NVF_SET: sel = SEL_NVF_SET;
                OFS_NVF_CLR: sel = SEL_NVF_CLR;
                OFS_RSTCTL:  sel = SEL_RSTCTL;
                OFS_K_PCI:   sel = SEL_K_PCI;
                OFS_K_LCD:   sel = SEL_K_LCD;
                OFS_K_TILE0: sel = SEL_K_TILE0;
                OFS_K_TILE1: sel = SEL_K_TILE1;
                default:     sel = in_window ? SEL_ZERO : SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sysreg_flagbank.sv
// sysreg_flagbank
// One flag register with separate write-one-to-set and write-one-to-clear
// strobes. Assumes at most one strobe per cycle; set wins if both are high.
module sysreg_flagbank #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    // Purpose: update the flag bits from set/clear strobes
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            q <= '0;
        end else if (set_en) begin
            q <= q | wdata;
        end else if (clr_en) begin
            q <= q & ~wdata;
        end
    end

endmodule

// File: rtl/sysreg_guard.sv
// sysreg_guard
// Key-protected reset control. Holds the lock word and the reset-level
// register, and emits a one-cycle reset request on an accepted write whose
// fire bit is set. Assumes DATA_W > FIRE_BIT and DATA_W >= KEY_W.
module sysreg_guard #(
    parameter int              DATA_W   = 32,
    parameter int              KEY_W    = 16,
    parameter logic [KEY_W-1:0] LOCK_KEY = 16'hA05F,
    parameter int              FIRE_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [KEY_W-1:0]  lock_q,
    output logic [DATA_W-1:0] ctl_q,
    output logic              unlocked,
    output logic              fire
);

    localparam logic [DATA_W-1:0] KEY_FULL = DATA_W'(LOCK_KEY);

    logic ctl_take;

    assign unlocked = (lock_q == LOCK_KEY);
    assign ctl_take = ctl_wr && unlocked;

    // Purpose: store the key exactly, or a value that can never match it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (lock_wr) begin
            if (wdata == KEY_FULL) begin
                lock_q <= LOCK_KEY;
            end else begin
                lock_q <= {1'b0, wdata[KEY_W-2:0]};
            end
        end
    end

    // Purpose: accept reset-level writes only while unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_take) begin
            ctl_q <= wdata;
        end
    end

    // Purpose: register a single-cycle reset request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire <= 1'b0;
        end else begin
            fire <= ctl_take && wdata[FIRE_BIT];
        end
    end

endmodule

// File: rtl/sysreg_lockfile.sv
// sysreg_lockfile
// Top of the lockable system control register file. Decodes bus accesses,
// holds the plain registers, instantiates the two flag banks and the
// key-protected reset control, and registers read data. Assumes a single
// access per cycle and word-aligned byte offsets.
module sysreg_lockfile
    import sysreg_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 32,
    parameter int              KEY_W    = 16,
    parameter logic [KEY_W-1:0] LOCK_KEY = 16'hA05F,
    parameter int              FIRE_BIT = 8,
    parameter logic [31:0]     SYS_ID   = 32'h1178_0500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] led_out,
    output logic              sys_reset_req,
    output logic              bad_access
);

    localparam int NBANK = 2;   // bank 0: volatile, bank 1: non-volatile

    sel_e                          sel;
    logic [DATA_W-1:0]             led_q;
    logic [DATA_W-1:0]             cfg_a_q;
    logic [DATA_W-1:0]             cfg_b_q;
    logic [KEY_W-1:0]              lock_q;
    logic [DATA_W-1:0]             rstctl_q;
    logic                          unlocked;
    logic [NBANK-1:0][DATA_W-1:0]  bank_q;
    logic [NBANK-1:0]              bank_set;
    logic [NBANK-1:0]              bank_clr;
    logic [DATA_W-1:0]             flag_q;
    logic [DATA_W-1:0]             nv_q;
    logic [DATA_W-1:0]             rd_mux;

    sysreg_decode #(
        .ADDR_W (ADDR_W)
    ) dec_i (
        .addr (bus_addr),
        .sel  (sel)
    );

    // Purpose: hold LED and config words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q   <= '0;
            cfg_a_q <= '0;
            cfg_b_q <= '0;
        end else if (bus_wr) begin
            if (sel == SEL_LED)   led_q   <= bus_wdata;
            if (sel == SEL_CFG_A) cfg_a_q <= bus_wdata;
            if (sel == SEL_CFG_B) cfg_b_q <= bus_wdata;
        end
    end

    assign led_out = led_q;

    // Purpose: build set/clear strobes for both flag banks
    always_comb begin
        bank_set[0] = bus_wr && (sel == SEL_FLG_SET);
        bank_clr[0] = bus_wr && (sel == SEL_FLG_CLR);
        bank_set[1] = bus_wr && (sel == SEL_NVF_SET);
        bank_clr[1] = bus_wr && (sel == SEL_NVF_CLR);
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sysreg_flagbank #(
            .DATA_W (DATA_W)
        ) bank_i (
            .clk    (clk),
            .clr_n  ((b == 1) ? por_n : rst_n),
            .set_en (bank_set[b]),
            .clr_en (bank_clr[b]),
            .wdata  (bus_wdata),
            .q      (bank_q[b])
        );
    end

    assign flag_q = bank_q[0];
    assign nv_q   = bank_q[1];

    sysreg_guard #(
        .DATA_W   (DATA_W),
        .KEY_W    (KEY_W),
        .LOCK_KEY (LOCK_KEY),
        .FIRE_BIT (FIRE_BIT)
    ) guard_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_wr  (bus_wr && (sel == SEL_LOCK)),
        .ctl_wr   (bus_wr && (sel == SEL_RSTCTL)),
        .wdata    (bus_wdata),
        .lock_q   (lock_q),
        .ctl_q    (rstctl_q),
        .unlocked (unlocked),
        .fire     (sys_reset_req)
    );

    // Purpose: select the read value for the decoded offset
    always_comb begin
        case (sel)
            SEL_ID:      rd_mux = DATA_W'(SYS_ID);
            SEL_LED:     rd_mux = led_q;
            SEL_LOCK:    rd_mux = DATA_W'(lock_q);
            SEL_CFG_A:   rd_mux = cfg_a_q;
            SEL_CFG_B:   rd_mux = cfg_b_q;
            SEL_FLG_SET: rd_mux = flag_q;
            SEL_NVF_SET: rd_mux = nv_q;
            SEL_RSTCTL:  rd_mux = rstctl_q;
            SEL_K_PCI:   rd_mux = DATA_W'(K_PCI_VAL);
            SEL_K_LCD:   rd_mux = DATA_W'(K_LCD_VAL);
            SEL_K_TILE0: rd_mux = DATA_W'(K_TILE0_VAL);
            SEL_K_TILE1: rd_mux = DATA_W'(K_TILE1_VAL);
            default:     rd_mux = '0;
        endcase
    end

    // Purpose: register read data on the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    // Purpose: remember any access outside the defined map
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_access <= 1'b0;
        end else if ((bus_rd || bus_wr) && (sel == SEL_NONE)) begin
            bad_access <= 1'b1;
        end
    end

endmodule

// File: rtl/sysreg_lockfile_chk.sv
// sysreg_lockfile_chk
// Property checker for sysreg_lockfile, attached by bind. Observes ports
// and the lock, reset-control and flag state of the top module.
module sysreg_lockfile_chk
    import sysreg_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 32,
    parameter int              KEY_W    = 16,
    parameter logic [KEY_W-1:0] LOCK_KEY = 16'hA05F,
    parameter int              FIRE_BIT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              sys_reset_req,
    input logic              bad_access,
    input logic [KEY_W-1:0]  lock_q,
    input logic [DATA_W-1:0] rstctl_q,
    input logic [DATA_W-1:0] flag_q,
    input logic [DATA_W-1:0] nv_q
);

    logic wr_lock, wr_ctl, wr_fclr, wr_nclr;

    assign wr_lock = bus_wr && (bus_addr == ADDR_W'(OFS_LOCK));
    assign wr_ctl  = bus_wr && (bus_addr == ADDR_W'(OFS_RSTCTL));
    assign wr_fclr = bus_wr && (bus_addr == ADDR_W'(OFS_FLG_CLR));
    assign wr_nclr = bus_wr && (bus_addr == ADDR_W'(OFS_NVF_CLR));

    // R4: a non-key write leaves the lock with its top bit clear
    a_r4_nonkey_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && (bus_wdata != DATA_W'(LOCK_KEY))) |=> !lock_q[KEY_W-1]);

    // R5: a locked write leaves the reset-control register unchanged
    a_r5_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && (lock_q != LOCK_KEY)) |=> $stable(rstctl_q));

    // R6: a reset request only follows an accepted write with the fire bit
    a_r6_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(wr_ctl && bus_wdata[FIRE_BIT] && (lock_q == LOCK_KEY)));

    // R7: clear write removes the written bits from the volatile flags
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fclr |=> ((flag_q & $past(bus_wdata)) == '0));

    // R8: clear write removes the written bits from the non-volatile flags
    a_r8_nvflag_clear: assert property (@(posedge clk) disable iff (!por_n)
        wr_nclr |=> ((nv_q & $past(bus_wdata)) == '0));

    // R9: soft reset without writes leaves the non-volatile flags alone
    a_r9_nv_survives: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && !bus_wr) |=> $stable(nv_q));

    // R10: read data holds in cycles without a read strobe
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R11: the error flag is sticky
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |=> bad_access);

endmodule

bind sysreg_lockfile sysreg_lockfile_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .KEY_W    (KEY_W),
    .LOCK_KEY (LOCK_KEY),
    .FIRE_BIT (FIRE_BIT)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_n         (por_n),
    .bus_addr      (bus_addr),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .sys_reset_req (sys_reset_req),
    .bad_access    (bad_access),
    .lock_q        (lock_q),
    .rstctl_q      (rstctl_q),
    .flag_q        (flag_q),
    .nv_q          (nv_q)
);

// File: tb/sysreg_lockfile_tb_top.sv
// sysreg_lockfile_tb_top
// Self-checking bench: offset sweeps, lock probing, flag models, pulse timing.
module sysreg_lockfile_tb_top;

    localparam logic [31:0] TB_SYS_ID = 32'h1178_0500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] led_out;
    logic        sys_reset_req;
    logic        bad_access;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sysreg_lockfile #(
        .ADDR_W (8),
        .DATA_W (32),
        .SYS_ID (TB_SYS_ID)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .por_n         (por_n),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .led_out       (led_out),
        .sys_reset_req (sys_reset_req),
        .bad_access    (bad_access)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic soft_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic power_reset();
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
    endtask

    function automatic bit is_undef(input logic [7:0] a);
        return (a[1:0] != 2'b00) || (a > 8'h74 && a < 8'h80) ||
               (a > 8'h9C && a < 8'hC0) || (a > 8'hD0);
    endfunction

    function automatic logic [31:0] idle_val(input logic [7:0] a);
        if (is_undef(a)) return 32'h0;
        case (a)
            8'h00:   return TB_SYS_ID;
            8'h44:   return 32'h1;
            8'h50:   return 32'h1000;
            8'h84:   return 32'h0200_0000;
            8'h88:   return 32'hFF00_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit has_state(input logic [7:0] a);
        return a inside {8'h08, 8'h20, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40};
    endfunction

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] seed;
        logic [31:0] mf;
        logic [31:0] mn;
        logic [31:0] sm;
        logic [31:0] cm;

        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;

        // R1: reset state at the ports
        check("R1 led_out after reset", led_out, 32'h0);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        check("R1 reset_req after reset", {31'h0, sys_reset_req}, 32'h0);
        check("R1 bad_access after reset", {31'h0, bad_access}, 32'h0);

        // R1 R2 R11: read sweep of every word offset after reset
        for (int w = 0; w < 64; w++) begin
            logic [7:0] a;
            a = 8'(w * 4);
            soft_reset();
            rd(a, d);
            check($sformatf("R2 read sweep ofs %h", a), d, idle_val(a));
            check($sformatf("R11 bad flag ofs %h", a), {31'h0, bad_access}, {31'h0, is_undef(a)});
        end

        // R2: writes to fixed and zero offsets have no effect
        soft_reset();
        for (int w = 0; w < 64; w++) begin
            logic [7:0] a;
            a = 8'(w * 4);
            if (!is_undef(a) && !has_state(a)) begin
                wr(a, 32'hFFFF_FFFF);
                rd(a, d);
                check($sformatf("R2 inert write ofs %h", a), d, idle_val(a));
            end
        end
        check("R2 led untouched by inert writes", led_out, 32'h0);
        check("R2 no bad flag on defined writes", {31'h0, bad_access}, 32'h0);
        check("R2 no reset pulse on inert writes", {31'h0, sys_reset_req}, 32'h0);
        rd(8'h30, d); check("R2 flags untouched", d, 32'h0);
        rd(8'h40, d); check("R2 rstctl untouched", d, 32'h0);

        // R3: plain registers
        wr(8'h08, 32'hDEAD_BEEF);
        check("R3 led_out follows LED", led_out, 32'hDEAD_BEEF);
        rd(8'h08, d); check("R3 LED readback", d, 32'hDEAD_BEEF);
        wr(8'h28, 32'h1357_9BDF);
        wr(8'h2C, 32'h0246_8ACE);
        rd(8'h28, d); check("R3 config A", d, 32'h1357_9BDF);
        rd(8'h2C, d); check("R3 config B", d, 32'h0246_8ACE);

        // R10: read data held without a read strobe
        wr(8'h08, 32'h0000_0022);
        check("R10 rdata holds across write", bus_rdata, 32'h0246_8ACE);
        @(negedge clk);
        check("R10 rdata holds idle", bus_rdata, 32'h0246_8ACE);

        // R11: unaligned and out-of-map writes change nothing, flag sticks
        check("R11 flag clear before", {31'h0, bad_access}, 32'h0);
        wr(8'h09, 32'hFFFF_FFFF);
        check("R11 unaligned write flags", {31'h0, bad_access}, 32'h1);
        check("R11 unaligned write no LED change", led_out, 32'h0000_0022);
        wr(8'hA0, 32'hFFFF_FFFF);
        rd(8'h08, d); check("R11 LED intact after bad writes", d, 32'h0000_0022);
        check("R11 flag still set", {31'h0, bad_access}, 32'h1);
        soft_reset();
        check("R11 flag cleared by rst_n", {31'h0, bad_access}, 32'h0);
        check("R1 LED cleared by rst_n", led_out, 32'h0);

        // R4: lock key storage
        wr(8'h20, 32'h1234_A05F); rd(8'h20, d); check("R4 key with upper bits", d, 32'h0000_205F);
        wr(8'h20, 32'h0000_FFFF); rd(8'h20, d); check("R4 bit15 forced low", d, 32'h0000_7FFF);
        wr(8'h20, 32'h0000_A05E); rd(8'h20, d); check("R4 near key", d, 32'h0000_205E);
        wr(8'h20, 32'h0000_8000); rd(8'h20, d); check("R4 only bit15", d, 32'h0000_0000);

        // R5 R6: locked writes are ignored
        wr(8'h40, 32'h0000_01FF);
        check("R6 no pulse while locked", {31'h0, sys_reset_req}, 32'h0);
        rd(8'h40, d); check("R5 locked write ignored", d, 32'h0);

        wr(8'h20, 32'h0000_A05F); rd(8'h20, d); check("R4 exact key stored", d, 32'h0000_A05F);

        // R6: accepted write with fire bit -> one-cycle pulse
        wr(8'h40, 32'h0000_0123);
        check("R6 pulse in cycle after write", {31'h0, sys_reset_req}, 32'h1);
        @(negedge clk);
        check("R6 pulse lasts one cycle", {31'h0, sys_reset_req}, 32'h0);
        rd(8'h40, d); check("R5 unlocked write stored", d, 32'h0000_0123);

        wr(8'h40, 32'hF0F0_0055);
        check("R6 no pulse with bit8 clear", {31'h0, sys_reset_req}, 32'h0);
        rd(8'h40, d); check("R5 second unlocked write", d, 32'hF0F0_0055);

        wr(8'h20, 32'h0000_0000);
        wr(8'h40, 32'h0000_0100);
        check("R6 no pulse after relock", {31'h0, sys_reset_req}, 32'h0);
        rd(8'h40, d); check("R5 relocked write ignored", d, 32'hF0F0_0055);

        // R7 R8: flag banks against a model
        mf = '0; mn = '0; seed = 32'hACE1_1234;
        for (int i = 0; i < 16; i++) begin
            seed = xs(seed); sm = seed;
            seed = xs(seed); cm = seed & 32'h5A5A_F00F;
            wr(8'h30, sm); mf = mf | sm;
            wr(8'h34, cm); mf = mf & ~cm;
            rd(8'h30, d); check($sformatf("R7 flags iter %0d", i), d, mf);
            wr(8'h38, ~sm); mn = mn | ~sm;
            wr(8'h3C, cm ^ 32'h00FF_00FF); mn = mn & ~(cm ^ 32'h00FF_00FF);
            rd(8'h38, d); check($sformatf("R8 nvflags iter %0d", i), d, mn);
        end
        rd(8'h34, d); check("R7 clear address reads 0", d, 32'h0);
        rd(8'h3C, d); check("R8 clear address reads 0", d, 32'h0);

        // R9: non-volatile flags survive soft reset, not power-on reset
        wr(8'h38, 32'hA5A5_0000); mn = mn | 32'hA5A5_0000;
        soft_reset();
        rd(8'h38, d); check("R9 nvflags kept over rst_n", d, mn);
        rd(8'h30, d); check("R1 flags cleared by rst_n", d, 32'h0);
        rd(8'h20, d); check("R1 lock cleared by rst_n", d, 32'h0);
        rd(8'h40, d); check("R1 rstctl cleared by rst_n", d, 32'h0);
        power_reset();
        rd(8'h38, d); check("R9 nvflags cleared by por_n", d, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule